// File: doc/BRIEF.md
# Four-Stage Pipeline Stall Controller

This block is the timing skeleton of an in-order pipeline with four steps: fetch, decode, execute and write. It carries instruction tokens (identifier, execute latency, load flag, register-write flag) through three interstage buffers. It generates every hold and bubble so that each token retires at the cycle its latency, fetch delays and write-port sharing allow. Tokens come in from an instruction-memory port. The block raises a request whenever the decode buffer can take a new token. A token is accepted in any cycle where that request meets the memory's ready.

Three causes of stall share one interlock. An execute operation may take several cycles. A fetch may miss and wait for the memory. A load has only one execute cycle, computing its address. It then spends two cycles in the write stage: a memory-access cycle, then its register-file write. The register file has a single write port. A younger instruction that has finished execute therefore waits one extra cycle behind a load. Priority runs from the write stage backwards. A stage that cannot move keeps its contents. A stage whose upstream neighbour cannot deliver receives a bubble.

Top module: `pipe4_stall_ctrl`

## Requirements
- R1: Synchronous active-high reset clears all three buffer valid bits and keeps `imem_req` low. In the first cycle after reset is released, `imem_req` is high.
- R2: With `imem_ready` held high and single-cycle execute, one token is accepted per cycle. A token accepted in cycle c is in decode in c+1, in execute in c+2 and retires in c+3.
- R3: While `imem_req` is high and `imem_ready` is low, no token is accepted and decode holds a bubble in the next cycle. A token delivered in cycle c is in decode in c+1.
- R4: A non-load token stays in execute for `lat` cycles, with a value of 0 treated as 1. Decode and fetch hold behind it, and the write stage receives a bubble.
- R5: A load (load flag 1) spends one cycle in execute. It then spends two cycles in the write stage: a memory cycle with no retire, then its write cycle.
- R6: The register-file write port (`rf_we`) is used at most once per cycle. It pulses exactly in a token's retire cycle and only when its register-write flag is 1. A token that finished execute while the write stage is busy stays in execute for one more cycle.
- R7: A stage that cannot advance keeps its token unchanged. A stage whose upstream neighbour does not deliver has its valid bit cleared. `stage_valid` bit 0 is decode, bit 1 execute, bit 2 write.
- R8: `retire_valid` pulses once per token, in the token's final write-stage cycle, carrying its identifier, and tokens retire in the order they were accepted.
- R9: `stall` is high exactly when a fetch request waits on memory, or a valid decode token cannot move, or a valid execute token cannot move.
- R10: `occupancy` equals the number of set bits in `stage_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_req | output | 1 | Fetch wants a token this cycle |
| imem_ready | input | 1 | Memory delivers the token this cycle |
| imem_id | input | ID_W | Token identifier |
| imem_lat | input | LAT_W | Execute latency in cycles |
| imem_load | input | 1 | Token is a load |
| imem_wr | input | 1 | Token writes the register file |
| stage_valid | output | 3 | Valid bits of decode, execute and write buffers |
| occupancy | output | 2 | Count of occupied buffers |
| stall | output | 1 | Some stage is held or fetch is waiting |
| rf_we | output | 1 | Register-file write port strobe |
| retire_valid | output | 1 | A token retires this cycle |
| retire_id | output | ID_W | Identifier of the retiring token |

## Verification
The first instruction stream runs single-cycle tokens back to back. It separates correct one-per-cycle flow from any spurious hold. Mixed latencies, including 0 and 3, show whether execute holds for exactly its count and whether bubbles reach the write stage. Streams with fetch misses of various lengths check when requests resume and how bubbles enter decode. Load-heavy streams, with loads back to back or ahead of multi-cycle and non-writing tokens, isolate the one-cycle write-port penalty. A final stream mixes all causes. Every cycle is compared with retire times derived from a latency recurrence.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
    parameter int ID_W  = 8;
    parameter int LAT_W = 4;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [LAT_W-1:0] lat;
        logic             ld;
        logic             wr;
    } tok_t;
endpackage

// File: rtl/pipe4_decode_buf.sv
module pipe4_decode_buf
    import pipe4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fetch_ok,
    input  tok_t fetch_tok,
    input  logic e_free,
    output logic d_valid,
    output tok_t d_tok,
    output logic d_move,
    output logic d_free
);
    typedef struct packed {
        logic v;
        tok_t t;
    } dstate_t;

    dstate_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        d_move = s_q.v & e_free;
        d_free = ~s_q.v | d_move;
        if (fetch_ok) begin
            s_d.v = 1'b1;
            s_d.t = fetch_tok;
        end else if (d_move) begin
            s_d.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign d_valid = s_q.v;
    assign d_tok   = s_q.t;

    // R7: a decode token that cannot move stays put
    p_dhold_r7: assert property (@(posedge clk) disable iff (rst)
        (s_q.v && !e_free) |=> (s_q.v && $stable(s_q.t)));
endmodule

// File: rtl/pipe4_exec.sv
module pipe4_exec
    import pipe4_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic d_move,
    input  tok_t d_tok,
    input  logic w_free,
    output logic e_valid,
    output tok_t e_tok,
    output logic e_move,
    output logic e_free
);
    typedef struct packed {
        logic             v;
        tok_t             t;
        logic [LAT_W-1:0] cnt;
    } estate_t;

    estate_t          s_d, s_q;
    logic [LAT_W-1:0] last;
    logic             e_done;

    always_comb begin
        if (s_q.t.ld || s_q.t.lat == '0) last = '0;
        else                             last = s_q.t.lat - LAT_W'(1);
        e_done = s_q.v && (s_q.cnt == last);
        e_move = e_done & w_free;
        e_free = ~s_q.v | e_move;
        s_d    = s_q;
        if (d_move) begin
            s_d.v   = 1'b1;
            s_d.t   = d_tok;
            s_d.cnt = '0;
        end else if (e_move) begin
            s_d.v = 1'b0;
        end else if (s_q.v && !e_done) begin
            s_d.cnt = s_q.cnt + LAT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign e_valid = s_q.v;
    assign e_tok   = s_q.t;

    // R4: execute keeps its token while it cannot leave
    p_ehold_r4: assert property (@(posedge clk) disable iff (rst)
        (s_q.v && !e_move) |=> (s_q.v && $stable(s_q.t.id)));
endmodule

// File: rtl/pipe4_write.sv
module pipe4_write
    import pipe4_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            e_move,
    input  tok_t            e_tok,
    output logic            w_valid,
    output logic            w_free,
    output logic            retire_valid,
    output logic [ID_W-1:0] retire_id,
    output logic            rf_we
);
    typedef struct packed {
        logic v;
        tok_t t;
        logic ph;
    } wstate_t;

    wstate_t s_d, s_q;
    logic    w_done;

    always_comb begin
        w_done = s_q.v && (!s_q.t.ld || s_q.ph);
        w_free = ~s_q.v | w_done;
        s_d    = s_q;
        if (e_move) begin
            s_d.v  = 1'b1;
            s_d.t  = e_tok;
            s_d.ph = 1'b0;
        end else if (w_done) begin
            s_d.v = 1'b0;
        end else if (s_q.v) begin
            s_d.ph = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign w_valid      = s_q.v;
    assign retire_valid = w_done;
    assign retire_id    = s_q.t.id;
    assign rf_we        = w_done & s_q.t.wr;

    // R5: memory cycle of a load is followed by its retire
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (s_q.v && s_q.t.ld && !s_q.ph) |=> (retire_valid && $stable(s_q.t.id)));
endmodule

// File: rtl/pipe4_stall_ctrl.sv
module pipe4_stall_ctrl
    import pipe4_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    output logic             imem_req,
    input  logic             imem_ready,
    input  logic [ID_W-1:0]  imem_id,
    input  logic [LAT_W-1:0] imem_lat,
    input  logic             imem_load,
    input  logic             imem_wr,
    output logic [2:0]       stage_valid,
    output logic [1:0]       occupancy,
    output logic             stall,
    output logic             rf_we,
    output logic             retire_valid,
    output logic [ID_W-1:0]  retire_id
);
    tok_t fetch_tok, d_tok, e_tok;
    logic d_valid, d_move, d_free;
    logic e_valid, e_move, e_free;
    logic w_valid, w_free;
    logic fetch_ok;

    assign fetch_tok = '{id: imem_id, lat: imem_lat, ld: imem_load, wr: imem_wr};
    assign imem_req  = ~rst & d_free;
    assign fetch_ok  = imem_req & imem_ready;

    pipe4_decode_buf u_dec (
        .clk(clk), .rst(rst), .fetch_ok(fetch_ok), .fetch_tok(fetch_tok),
        .e_free(e_free), .d_valid(d_valid), .d_tok(d_tok),
        .d_move(d_move), .d_free(d_free)
    );

    pipe4_exec u_exe (
        .clk(clk), .rst(rst), .d_move(d_move), .d_tok(d_tok),
        .w_free(w_free), .e_valid(e_valid), .e_tok(e_tok),
        .e_move(e_move), .e_free(e_free)
    );

    pipe4_write u_wb (
        .clk(clk), .rst(rst), .e_move(e_move), .e_tok(e_tok),
        .w_valid(w_valid), .w_free(w_free), .retire_valid(retire_valid),
        .retire_id(retire_id), .rf_we(rf_we)
    );

    assign stage_valid = {w_valid, e_valid, d_valid};
    assign occupancy   = {1'b0, d_valid} + {1'b0, e_valid} + {1'b0, w_valid};
    assign stall       = (imem_req & ~imem_ready) | (d_valid & ~e_free) | (e_valid & ~e_move);

    // R1: fetch request rises right after reset release
    p_req_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> imem_req);

    // R3: an unanswered request leaves decode empty next cycle
    p_miss_r3: assert property (@(posedge clk) disable iff (rst)
        (imem_req && !imem_ready) |=> !stage_valid[0]);

    // R6: write stage never holds a token for more than two cycles
    p_port_r6: assert property (@(posedge clk) disable iff (rst)
        (stage_valid[2] && !retire_valid) |=> retire_valid);
endmodule

// File: tb/pipe4_stall_ctrl_test.sv
`timescale 1ns/1ps
module pipe4_stall_ctrl_test;
    import pipe4_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             imem_req, imem_ready;
    logic [ID_W-1:0]  imem_id;
    logic [LAT_W-1:0] imem_lat;
    logic             imem_load, imem_wr;
    logic [2:0]       stage_valid;
    logic [1:0]       occupancy;
    logic             stall, rf_we, retire_valid;
    logic [ID_W-1:0]  retire_id;

    int errors = 0;
    int checks = 0;
    int cyc_total = 0;

    int lat_a[16], ld_a[16], wr_a[16], miss_a[16];

    always #4 clk = ~clk;

    pipe4_stall_ctrl uut (
        .clk(clk), .rst(rst), .imem_req(imem_req), .imem_ready(imem_ready),
        .imem_id(imem_id), .imem_lat(imem_lat), .imem_load(imem_load),
        .imem_wr(imem_wr), .stage_valid(stage_valid), .occupancy(occupancy),
        .stall(stall), .rf_we(rf_we), .retire_valid(retire_valid),
        .retire_id(retire_id)
    );

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp, input int c);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, c, act, exp);
        end
    endtask

    task automatic set_tok(input int k, input int lat, input int ld, input int wr, input int miss);
        lat_a[k] = lat; ld_a[k] = ld; wr_a[k] = wr; miss_a[k] = miss;
    endtask

    task automatic run_prog(input string tag, input int n, input int idbase);
        int tD[16], tE[16], tW[16], rt[16], s[17], fc[16];
        int ncyc, fi, wcnt;
        for (int k = 0; k < n; k++) begin
            int dur;
            s[k]  = (k == 0) ? 0 : tE[k-1] - 1;
            fc[k] = s[k] + miss_a[k];
            tD[k] = fc[k] + 1;
            dur   = ld_a[k] ? 1 : ((lat_a[k] == 0) ? 1 : lat_a[k]);
            tE[k] = tD[k] + 1;
            if (k > 0 && tW[k-1] > tE[k]) tE[k] = tW[k-1];
            tW[k] = tE[k] + dur;
            if (k > 0 && rt[k-1] + 1 > tW[k]) tW[k] = rt[k-1] + 1;
            rt[k] = tW[k] + ld_a[k];
        end
        s[n] = tE[n-1] - 1;
        ncyc = rt[n-1] + 4;

        @(negedge clk);
        rst = 1'b1; imem_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset valid bits", stage_valid, 0, -1);
        chk("R1 reset request", imem_req, 0, -1);
        chk("R8 reset retire", retire_valid, 0, -1);
        rst = 1'b0;
        fi = 0; wcnt = 0;
        for (int c = 0; c < ncyc; c++) begin
            int e_req, e_stall, dv, ev, wv, e_ret, e_rid, e_we;
            if (c > 0) @(negedge clk);
            if (fi < n) begin
                imem_ready = (wcnt >= miss_a[fi]);
                imem_id    = ID_W'(idbase + fi);
                imem_lat   = LAT_W'(lat_a[fi]);
                imem_load  = ld_a[fi][0];
                imem_wr    = wr_a[fi][0];
            end else begin
                imem_ready = 1'b0;
                imem_id = '0; imem_lat = '0; imem_load = 1'b0; imem_wr = 1'b0;
            end
            #1;
            e_req = (c >= s[n]); e_stall = (c >= s[n]);
            dv = 0; ev = 0; wv = 0; e_ret = 0; e_rid = 0; e_we = 0;
            for (int k = 0; k < n; k++) begin
                if (c >= s[k] && c <= fc[k]) e_req = 1;
                if (c >= s[k] && c < fc[k]) e_stall = 1;
                if (c >= tD[k] && c < tE[k] - 1) e_stall = 1;
                if (c >= tE[k] && c < tW[k] - 1) e_stall = 1;
                if (c >= tD[k] && c <= tE[k] - 1) dv = 1;
                if (c >= tE[k] && c <= tW[k] - 1) ev = 1;
                if (c >= tW[k] && c <= rt[k]) wv = 1;
                if (c == rt[k]) begin
                    e_ret = 1; e_rid = idbase + k; e_we = wr_a[k];
                end
            end
            chk({tag, " R3 fetch request"}, imem_req, e_req, c);
            chk({tag, " R9 stall"}, stall, e_stall, c);
            chk({tag, " R7 stage valid"}, stage_valid, wv * 4 + ev * 2 + dv, c);
            chk("R10 occupancy", occupancy, wv + ev + dv, c);
            chk({tag, " R8 retire valid"}, retire_valid, e_ret, c);
            if (e_ret) chk({tag, " R8 retire id"}, retire_id, e_rid, c);
            chk({tag, " R6 write port"}, rf_we, e_we, c);
            if (imem_req && imem_ready) begin
                fi++; wcnt = 0;
            end else if (imem_req) begin
                wcnt++;
            end
        end
    endtask

    initial begin
        imem_ready = 1'b0; imem_id = '0; imem_lat = '0; imem_load = 1'b0; imem_wr = 1'b0;

        // R2: single-cycle stream without misses
        for (int k = 0; k < 6; k++) set_tok(k, 1, 0, 1, 0);
        run_prog("R2 back-to-back", 6, 16);

        // R4: execute latencies including 0 and 3
        set_tok(0, 1, 0, 1, 0); set_tok(1, 3, 0, 1, 0); set_tok(2, 1, 0, 1, 0);
        set_tok(3, 0, 0, 1, 0); set_tok(4, 2, 0, 0, 0); set_tok(5, 1, 0, 1, 0);
        run_prog("R4 multi-cycle execute", 6, 32);

        // R3: fetch misses of several lengths
        set_tok(0, 1, 0, 1, 0); set_tok(1, 1, 0, 1, 3); set_tok(2, 1, 0, 1, 0);
        set_tok(3, 1, 0, 1, 1); set_tok(4, 1, 0, 1, 0); set_tok(5, 1, 0, 1, 5);
        run_prog("R3 fetch miss", 6, 48);

        // R5 R6: loads contending for the write port
        set_tok(0, 1, 0, 1, 0); set_tok(1, 1, 1, 1, 0); set_tok(2, 1, 0, 1, 0);
        set_tok(3, 2, 1, 1, 0); set_tok(4, 1, 1, 1, 0); set_tok(5, 1, 0, 0, 0);
        set_tok(6, 3, 0, 1, 0); set_tok(7, 1, 1, 1, 0);
        run_prog("R5 R6 load contention", 8, 64);

        // R7: all causes mixed
        set_tok(0, 2, 0, 1, 2); set_tok(1, 1, 1, 1, 0); set_tok(2, 3, 0, 0, 0);
        set_tok(3, 1, 1, 1, 4); set_tok(4, 1, 0, 1, 0); set_tok(5, 0, 1, 0, 1);
        set_tok(6, 4, 0, 1, 0); set_tok(7, 1, 0, 1, 0); set_tok(8, 1, 1, 1, 2);
        run_prog("R7 mixed hazards", 9, 96);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule